// File: doc/BRIEF.md
# DRAM Frequency-Change Sequencer

This block carries out the memory-side steps of a DRAM clock-rate change in hardware, with no software in the loop. It is started by a single request pulse. It then acts as a master on a simple register bus and completes the following steps in a fixed order:

1. It parks the DRAM in self-refresh and holds off all other masters.
2. It latches the new DDR PLL setting and lets the PLL settle.
3. It retrains the PHY with a rank setting taken from the controller.
4. It programs on-die termination on every byte lane.
5. It releases self-refresh.

The PLL divider values for the new rate must be programmed before the request. The block only sets the latch bit. An internal timer provides the microsecond waits; it counts clock ticks derived from a counter-frequency parameter.

Each status poll is guarded by a miss limit. If a status field fails to reach its target value in time, the block stops the sequence. It then clears the self-refresh and master-hold bits so the memory is not left parked, and reports an error code. The caller watches `busy` for the duration of the sequence. It reads `result` in the cycle that `done` pulses.

Top module: `dfs_freq_seq`

## Requirements
- R1: After reset, `busy`, `done`, `bus_rd` and `bus_wr` are low and `result` is 0.
- R2: A `req` seen while idle starts the sequence. The first access is a read of the power-control register. It is followed by a write of the same value with bits 0 (self-refresh request) and 8 (master hold) set.
- R3: No status poll is issued until at least TICKS_PER_US×1 clocks after the power-control write, the PHY-start write and the exit write complete. The controller-mode read after the PLL write waits at least TICKS_PER_US×1000 clocks. TICKS_PER_US is CNT_FREQ_HZ / 1 000 000.
- R4: The status register is read repeatedly until its bits 2:0 equal 3. Its other bits are ignored.
- R5: The PLL control register is read and written back with bit 20 set. All other bits are unchanged.
- R6: Bit 0 of the controller-mode register selects the rank setting. A value of 1 writes 2'b11 into bits 25:24 of the training register; a value of 0 writes 2'b01. All other bits are preserved.
- R7: The PHY-start register is written with 32'h4000_0061. PHY status is then polled until its bit 0 is 1.
- R8: The byte-lane registers are updated lane 0 first through lane 3, at lane-0 address + 0x80×index. Bits 5:4 become 2'b10 when `odt_dyn` (latched at the request) is 0 and 2'b00 when it is 1. The other bits are preserved.
- R9: The exit step reads power-control and writes it back with bits 0 and 8 cleared. It then polls status until bits 2:0 equal 1, and pulses `done` for one cycle with `result` = 0.
- R10: `busy` is high from the cycle after an accepted request until the `done` cycle. A `req` while busy changes nothing, and the latched ODT mode is kept.
- R11: After POLL_MAX consecutive non-matching reads in one poll phase, the block stops the sequence. It read-modify-writes power-control with bits 0 and 8 cleared, then pulses `done` with `result` 1 (entry), 2 (PHY lock) or 3 (exit). POLL_MAX−1 misses still succeed.
- R12: Only one transaction is outstanding at a time. `bus_rd` and `bus_wr` are never both high. Strobe, address and write data are held until `bus_ready`. No access occurs while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start request, sampled while idle |
| odt_dyn | input | 1 | 1: dynamic ODT on lanes, 0: ODT off |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ok, 1 entry timeout, 2 PHY timeout, 3 exit timeout |
| bus_addr | output | AW | Register address |
| bus_wdata | output | 32 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_ready | input | 1 | Transaction completes at this edge |
| bus_rdata | input | 32 | Read data, valid with bus_ready |

## Verification
The bound checker watches several properties on every cycle:
- the bus handshake: exclusive strobes, address and data held while stalled, and silence while idle;
- that a sequence only starts from a request;
- the single-cycle `done` that returns to idle;
- that every PLL write carries the latch bit and every power-control write moves both hold bits together.

Other behaviours can only be shown by the scenario bench. These are the full ordering of accesses, the preserved bits in each read-modify-write, and the minimum wait lengths. They also include the rank and ODT choices, rejection of a second request with a changed ODT input, and the miss-limit boundary with its three error codes and recovery writes.

// File: rtl/dfs_pkg.sv
package dfs_pkg;

    localparam int DW = 32;

    typedef enum logic [4:0] {
        S_IDLE,
        S_SR_RD,   S_SR_WR,   S_SR_WAIT,  S_SR_POLL,
        S_PLL_RD,  S_PLL_WR,  S_PLL_WAIT,
        S_RANK_RD, S_TRN_RD,  S_TRN_WR,
        S_PHY_GO,  S_PHY_WAIT, S_PHY_POLL,
        S_LANE_RD, S_LANE_WR,
        S_EX_RD,   S_EX_WR,   S_EX_WAIT,  S_EX_POLL,
        S_AB_RD,   S_AB_WR,
        S_FIN
    } dfs_state_e;

    localparam logic [1:0] RES_OK    = 2'd0;
    localparam logic [1:0] RES_ENTRY = 2'd1;
    localparam logic [1:0] RES_PHY   = 2'd2;
    localparam logic [1:0] RES_EXIT  = 2'd3;

    // self-refresh request (bit 0) and master hold (bit 8)
    localparam logic [DW-1:0] PWR_HOLD_BITS = 32'h0000_0101;
    localparam int            PLL_LATCH_BIT = 20;
    localparam logic [DW-1:0] PHY_KICK      = 32'h4000_0061;
    localparam logic [2:0]    ST_IN_SR      = 3'd3;
    localparam logic [2:0]    ST_NORMAL     = 3'd1;

endpackage

// File: rtl/dfs_us_timer.sv
module dfs_us_timer #(
    parameter int unsigned TICKS_PER_US = 24,
    parameter int unsigned SHORT_US     = 1,
    parameter int unsigned LONG_US      = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic long_sel,
    output logic expired
);
    localparam int unsigned SHORT_T = TICKS_PER_US * SHORT_US;
    localparam int unsigned LONG_T  = TICKS_PER_US * LONG_US;
    localparam int unsigned CW      = $clog2(LONG_T + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = long_sel ? CW'(LONG_T) : CW'(SHORT_T);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/dfs_poll_guard.sv
module dfs_poll_guard #(
    parameter int unsigned LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic miss,
    output logic last
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (miss) cnt_d = cnt_q + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // the miss now being reported is the LIMIT-th one
    assign last = (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/dfs_freq_seq.sv
module dfs_freq_seq
    import dfs_pkg::*;
#(
    parameter int unsigned AW           = 32,
    parameter int unsigned CNT_FREQ_HZ  = 24_000_000,
    parameter int unsigned POLL_MAX     = 64,
    parameter int unsigned LANES        = 4,
    parameter int unsigned LANE_STRIDE  = 32'h80,
    parameter logic [AW-1:0] A_PWR      = AW'(32'h0000_0100),
    parameter logic [AW-1:0] A_STAT     = AW'(32'h0000_0104),
    parameter logic [AW-1:0] A_MODE     = AW'(32'h0000_0000),
    parameter logic [AW-1:0] A_TRAIN    = AW'(32'h0000_0110),
    parameter logic [AW-1:0] A_PHYINIT  = AW'(32'h0000_0120),
    parameter logic [AW-1:0] A_PHYSTAT  = AW'(32'h0000_0124),
    parameter logic [AW-1:0] A_LANE0    = AW'(32'h0000_0200),
    parameter logic [AW-1:0] A_PLL      = AW'(32'h0000_0400)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          odt_dyn,
    output logic          busy,
    output logic          done,
    output logic [1:0]    result,
    output logic [AW-1:0] bus_addr,
    output logic [31:0]   bus_wdata,
    output logic          bus_wr,
    output logic          bus_rd,
    input  logic          bus_ready,
    input  logic [31:0]   bus_rdata
);
    localparam int unsigned TICKS_PER_US =
        (CNT_FREQ_HZ >= 1_000_000) ? CNT_FREQ_HZ / 1_000_000 : 1;
    localparam int unsigned LW = (LANES > 1) ? $clog2(LANES) : 1;

    typedef struct packed {
        dfs_state_e     st;
        logic [DW-1:0]  data;
        logic [LW-1:0]  lane;
        logic           rank;
        logic           odt;
        logic [1:0]     err;
    } seq_t;

    seq_t r_q, r_d;

    logic tmr_start, tmr_long, tmr_exp;
    logic grd_clr, grd_miss, grd_last;

    logic [AW-1:0] lane_addr [LANES];
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_addr[g] = A_LANE0 + AW'(g * LANE_STRIDE);
    end

    dfs_us_timer #(
        .TICKS_PER_US (TICKS_PER_US),
        .SHORT_US     (1),
        .LONG_US      (1000)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tmr_start),
        .long_sel (tmr_long),
        .expired  (tmr_exp)
    );

    dfs_poll_guard #(.LIMIT(POLL_MAX)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (grd_clr),
        .miss  (grd_miss),
        .last  (grd_last)
    );

    always_comb begin
        r_d       = r_q;
        bus_addr  = '0;
        bus_wdata = r_q.data;
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        tmr_start = 1'b0;
        tmr_long  = 1'b0;
        grd_clr   = 1'b0;
        grd_miss  = 1'b0;
        done      = 1'b0;

        unique case (r_q.st)
            S_IDLE: begin
                grd_clr = 1'b1;
                if (req) begin
                    r_d.odt = odt_dyn;
                    r_d.err = RES_OK;
                    r_d.st  = S_SR_RD;
                end
            end
            // ---- self-refresh entry ----
            S_SR_RD: begin
                bus_rd = 1'b1; bus_addr = A_PWR;
                if (bus_ready) begin
                    r_d.data = bus_rdata | PWR_HOLD_BITS;
                    r_d.st   = S_SR_WR;
                end
            end
            S_SR_WR: begin
                bus_wr = 1'b1; bus_addr = A_PWR;
                if (bus_ready) begin
                    tmr_start = 1'b1;
                    r_d.st    = S_SR_WAIT;
                end
            end
            S_SR_WAIT: begin
                grd_clr = 1'b1;
                if (tmr_exp) r_d.st = S_SR_POLL;
            end
            S_SR_POLL: begin
                bus_rd = 1'b1; bus_addr = A_STAT;
                if (bus_ready) begin
                    if (bus_rdata[2:0] == ST_IN_SR) begin
                        r_d.st = S_PLL_RD;
                    end else begin
                        grd_miss = 1'b1;
                        if (grd_last) begin
                            r_d.err = RES_ENTRY;
                            r_d.st  = S_AB_RD;
                        end
                    end
                end
            end
            // ---- PLL latch and settle ----
            S_PLL_RD: begin
                bus_rd = 1'b1; bus_addr = A_PLL;
                if (bus_ready) begin
                    r_d.data = bus_rdata | (DW'(1) << PLL_LATCH_BIT);
                    r_d.st   = S_PLL_WR;
                end
            end
            S_PLL_WR: begin
                bus_wr = 1'b1; bus_addr = A_PLL;
                if (bus_ready) begin
                    tmr_start = 1'b1;
                    tmr_long  = 1'b1;
                    r_d.st    = S_PLL_WAIT;
                end
            end
            S_PLL_WAIT: begin
                if (tmr_exp) r_d.st = S_RANK_RD;
            end
            // ---- rank-dependent training setup ----
            S_RANK_RD: begin
                bus_rd = 1'b1; bus_addr = A_MODE;
                if (bus_ready) begin
                    r_d.rank = bus_rdata[0];
                    r_d.st   = S_TRN_RD;
                end
            end
            S_TRN_RD: begin
                bus_rd = 1'b1; bus_addr = A_TRAIN;
                if (bus_ready) begin
                    r_d.data = {bus_rdata[31:26], r_q.rank, 1'b1, bus_rdata[23:0]};
                    r_d.st   = S_TRN_WR;
                end
            end
            S_TRN_WR: begin
                bus_wr = 1'b1; bus_addr = A_TRAIN;
                if (bus_ready) r_d.st = S_PHY_GO;
            end
            // ---- PHY reset and DLL calibration ----
            S_PHY_GO: begin
                bus_wr = 1'b1; bus_addr = A_PHYINIT; bus_wdata = PHY_KICK;
                if (bus_ready) begin
                    tmr_start = 1'b1;
                    r_d.st    = S_PHY_WAIT;
                end
            end
            S_PHY_WAIT: begin
                grd_clr = 1'b1;
                if (tmr_exp) r_d.st = S_PHY_POLL;
            end
            S_PHY_POLL: begin
                bus_rd = 1'b1; bus_addr = A_PHYSTAT;
                if (bus_ready) begin
                    if (bus_rdata[0]) begin
                        r_d.lane = '0;
                        r_d.st   = S_LANE_RD;
                    end else begin
                        grd_miss = 1'b1;
                        if (grd_last) begin
                            r_d.err = RES_PHY;
                            r_d.st  = S_AB_RD;
                        end
                    end
                end
            end
            // ---- per-lane termination ----
            S_LANE_RD: begin
                bus_rd = 1'b1; bus_addr = lane_addr[r_q.lane];
                if (bus_ready) begin
                    r_d.data = {bus_rdata[31:6], (r_q.odt ? 2'b00 : 2'b10), bus_rdata[3:0]};
                    r_d.st   = S_LANE_WR;
                end
            end
            S_LANE_WR: begin
                bus_wr = 1'b1; bus_addr = lane_addr[r_q.lane];
                if (bus_ready) begin
                    if (r_q.lane == LW'(LANES - 1)) begin
                        r_d.st = S_EX_RD;
                    end else begin
                        r_d.lane = r_q.lane + LW'(1);
                        r_d.st   = S_LANE_RD;
                    end
                end
            end
            // ---- self-refresh exit ----
            S_EX_RD: begin
                bus_rd = 1'b1; bus_addr = A_PWR;
                if (bus_ready) begin
                    r_d.data = bus_rdata & ~PWR_HOLD_BITS;
                    r_d.st   = S_EX_WR;
                end
            end
            S_EX_WR: begin
                bus_wr = 1'b1; bus_addr = A_PWR;
                if (bus_ready) begin
                    tmr_start = 1'b1;
                    r_d.st    = S_EX_WAIT;
                end
            end
            S_EX_WAIT: begin
                grd_clr = 1'b1;
                if (tmr_exp) r_d.st = S_EX_POLL;
            end
            S_EX_POLL: begin
                bus_rd = 1'b1; bus_addr = A_STAT;
                if (bus_ready) begin
                    if (bus_rdata[2:0] == ST_NORMAL) begin
                        r_d.st = S_FIN;
                    end else begin
                        grd_miss = 1'b1;
                        if (grd_last) begin
                            r_d.err = RES_EXIT;
                            r_d.st  = S_AB_RD;
                        end
                    end
                end
            end
            // ---- abort: release the hold bits ----
            S_AB_RD: begin
                bus_rd = 1'b1; bus_addr = A_PWR;
                if (bus_ready) begin
                    r_d.data = bus_rdata & ~PWR_HOLD_BITS;
                    r_d.st   = S_AB_WR;
                end
            end
            S_AB_WR: begin
                bus_wr = 1'b1; bus_addr = A_PWR;
                if (bus_ready) r_d.st = S_FIN;
            end
            S_FIN: begin
                done   = 1'b1;
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: S_IDLE, data: '0, lane: '0, rank: 1'b0, odt: 1'b0, err: RES_OK};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy   = (r_q.st != S_IDLE);
    assign result = r_q.err;
endmodule

// File: rtl/dfs_seq_checker.sv
module dfs_seq_checker #(
    parameter int unsigned   AW    = 32,
    parameter logic [AW-1:0] A_PWR = '0,
    parameter logic [AW-1:0] A_PLL = '0
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] bus_addr,
    input logic [31:0]   bus_wdata,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          bus_ready
);
    a_r12_excl_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));

    a_r12_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) && !bus_ready |=>
            bus_rd == $past(bus_rd) && bus_wr == $past(bus_wr) &&
            bus_addr == $past(bus_addr) && bus_wdata == $past(bus_wdata));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_rd && !bus_wr);

    a_r10_start_by_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done && !busy);

    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r5_pll_latch: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_PLL |-> bus_wdata[20]);

    a_r2_pwr_pair: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr && bus_addr == A_PWR |-> bus_wdata[0] == bus_wdata[8]);
endmodule

bind dfs_freq_seq dfs_seq_checker #(
    .AW    (AW),
    .A_PWR (A_PWR),
    .A_PLL (A_PLL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .busy      (busy),
    .done      (done),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_ready (bus_ready)
);

// File: tb/dfs_freq_seq_test.sv
module dfs_freq_seq_test;
    localparam int T  = 3;   // ticks per microsecond
    localparam int PM = 5;   // poll miss limit
    localparam logic [31:0] A_PWR = 32'h100, A_STAT = 32'h104, A_MODE = 32'h000;
    localparam logic [31:0] A_TRAIN = 32'h110, A_PHYINIT = 32'h120, A_PHYSTAT = 32'h124;
    localparam logic [31:0] A_LANE0 = 32'h200, A_PLL = 32'h400;

    logic clk = 0, rst_n = 0, req = 0, odt_dyn = 0;
    logic busy, done, bus_wr, bus_rd;
    logic [1:0] result;
    logic [31:0] bus_addr, bus_wdata;
    logic bus_ready = 0;
    logic [31:0] bus_rdata = '0;

    always #2ns clk = ~clk;

    dfs_freq_seq #(
        .AW(32), .CNT_FREQ_HZ(T * 1_000_000), .POLL_MAX(PM), .LANES(4), .LANE_STRIDE(32'h80),
        .A_PWR(A_PWR), .A_STAT(A_STAT), .A_MODE(A_MODE), .A_TRAIN(A_TRAIN),
        .A_PHYINIT(A_PHYINIT), .A_PHYSTAT(A_PHYSTAT), .A_LANE0(A_LANE0), .A_PLL(A_PLL)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .odt_dyn(odt_dyn), .busy(busy), .done(done),
        .result(result), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_ready(bus_ready), .bus_rdata(bus_rdata)
    );

    int total = 0, bad = 0;
    longint cyc = 0, last_cyc = 0;
    always @(posedge clk) cyc++;

    typedef struct {
        bit          wr;
        logic [31:0] addr;
        logic [31:0] data;
        int          gap;
        string       tag;
    } item_t;
    item_t sb[$];

    // register-file model of the controller, PHY and clock unit
    logic [31:0] m_pwr, m_pll, m_mode, m_train, m_phy;
    logic [31:0] m_lane [4];
    logic [31:0] lane_init [4];
    int sr_left, ph_left, ex_left, lat, wcnt;

    task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", rq, act, expv);
        end
    endtask

    task automatic push(input bit wr, input logic [31:0] a, input logic [31:0] d, input int gap, input string tag);
        item_t it;
        it.wr = wr; it.addr = a; it.data = d; it.gap = gap; it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic model_read(input logic [31:0] a, output logic [31:0] v);
        v = 32'hDEAD_0000;
        if (a == A_PWR) v = m_pwr;
        else if (a == A_PLL) v = m_pll;
        else if (a == A_MODE) v = m_mode;
        else if (a == A_TRAIN) v = m_train;
        else if (a == A_STAT) begin
            if (m_pwr[0]) begin
                if (sr_left > 0) begin sr_left--; v = 32'hA8 | 32'd2; end
                else v = 32'hA8 | 32'd3;
            end else begin
                if (ex_left > 0) begin ex_left--; v = 32'hA8 | 32'd3; end
                else v = 32'hA8 | 32'd1;
            end
        end else if (a == A_PHYSTAT) begin
            if (ph_left > 0) begin ph_left--; v = 32'hFFFF_FFFE; end
            else v = 32'h8000_0001;
        end else begin
            for (int i = 0; i < 4; i++)
                if (a == A_LANE0 + 32'h80 * i) v = m_lane[i];
        end
    endtask

    task automatic model_write(input logic [31:0] a, input logic [31:0] d);
        if (a == A_PWR) m_pwr = d;
        else if (a == A_PLL) m_pll = d;
        else if (a == A_TRAIN) m_train = d;
        else if (a == A_PHYINIT) m_phy = d;
        else for (int i = 0; i < 4; i++)
            if (a == A_LANE0 + 32'h80 * i) m_lane[i] = d;
    endtask

    // responder and scoreboard monitor
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ready = 0; wcnt = 0;
        end else if (bus_ready) begin
            bus_ready = 0; wcnt = 0;
        end else if (bus_rd || bus_wr) begin
            if (wcnt < lat) wcnt++;
            else begin
                if (sb.size() == 0) begin
                    check(0, "R12 unexpected access", bus_addr, 32'hFFFF_FFFF);
                end else begin
                    item_t e;
                    logic [31:0] v;
                    e = sb.pop_front();
                    check(e.wr == bus_wr && e.addr == bus_addr, {e.tag, " access kind/address"},
                          {bus_wr, bus_addr[30:0]}, {e.wr, e.addr[30:0]});
                    if (e.wr && bus_wr)
                        check(e.data == bus_wdata, {e.tag, " write data"}, bus_wdata, e.data);
                    if (e.gap > 0)
                        check(cyc - last_cyc >= e.gap, "R3 wait length",
                              32'(cyc - last_cyc), 32'(e.gap));
                end
                last_cyc = cyc;
                if (bus_wr) model_write(bus_addr, bus_wdata);
                else begin
                    logic [31:0] rv;
                    model_read(bus_addr, rv);
                    bus_rdata = rv;
                end
                bus_ready = 1;
            end
        end
    end

    task automatic push_polls(input int misses, input logic [31:0] a, input string tag);
        int n = (misses >= PM) ? PM : misses + 1;
        for (int i = 0; i < n; i++) push(0, a, 0, (i == 0) ? T : 0, tag);
    endtask

    task automatic run(input bit rank, input bit odt, input int srm, input int phm, input int exm,
                       input int lt, input bit poke, input logic [1:0] want, input string rtag);
        logic [31:0] p;
        bit seen;
        m_mode = 32'hFFFF_FFFE | {31'b0, rank};
        sr_left = srm; ph_left = phm; ex_left = exm; lat = lt;
        p = m_pwr | 32'h101;
        push(0, A_PWR, 0, 0, "R2"); push(1, A_PWR, p, 0, "R2");
        push_polls(srm, A_STAT, "R4");
        if (srm >= PM) begin
            push(0, A_PWR, 0, 0, "R11"); push(1, A_PWR, p & ~32'h101, 0, "R11");
        end else begin
            push(0, A_PLL, 0, 0, "R5"); push(1, A_PLL, m_pll | (32'h1 << 20), 0, "R5");
            push(0, A_MODE, 0, T * 1000, "R3");
            push(0, A_TRAIN, 0, 0, "R6");
            push(1, A_TRAIN, (m_train & ~(32'h3 << 24)) | ((rank ? 32'h3 : 32'h1) << 24), 0, "R6");
            push(1, A_PHYINIT, 32'h4000_0061, 0, "R7");
            push_polls(phm, A_PHYSTAT, "R7");
            if (phm >= PM) begin
                push(0, A_PWR, 0, 0, "R11"); push(1, A_PWR, p & ~32'h101, 0, "R11");
            end else begin
                for (int i = 0; i < 4; i++) begin
                    push(0, A_LANE0 + 32'h80 * i, 0, 0, "R8");
                    push(1, A_LANE0 + 32'h80 * i,
                         (m_lane[i] & ~32'h30) | (odt ? 32'h0 : 32'h20), 0, "R8");
                end
                push(0, A_PWR, 0, 0, "R9"); push(1, A_PWR, p & ~32'h101, 0, "R9");
                push_polls(exm, A_STAT, "R9");
                if (exm >= PM) begin
                    push(0, A_PWR, 0, 0, "R11"); push(1, A_PWR, p & ~32'h101, 0, "R11");
                end
            end
        end
        @(negedge clk); req = 1; odt_dyn = odt;
        @(negedge clk); req = 0;
        check(busy == 1, "R10 busy after request", {31'b0, busy}, 32'd1);
        if (poke) begin
            repeat (10) @(negedge clk);
            req = 1; odt_dyn = ~odt;   // R10: must be ignored, ODT kept
            @(negedge clk); req = 0;
        end
        seen = 0;
        for (int k = 0; k < 20000 && !seen; k++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        check(seen, {rtag, " done pulse"}, {31'b0, seen}, 32'd1);
        check(result == want, {rtag, " result code"}, {30'b0, result}, {30'b0, want});
        @(negedge clk);
        check(!busy && !done, "R10 idle after done", {30'b0, busy, done}, 32'd0);
        repeat (30) @(negedge clk);
        check(sb.size() == 0, "R12 all expected accesses seen", 32'(sb.size()), 32'd0);
        check(!busy, "R10 no restart from ignored request", {31'b0, busy}, 32'd0);
        sb.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 32'(cyc), 32'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_pwr = 32'h0000_00F0; m_pll = 32'h8000_1234; m_train = 32'h1200_0055; m_phy = '0;
        m_mode = '0; sr_left = 0; ph_left = 0; ex_left = 0; lat = 0; wcnt = 0;
        for (int i = 0; i < 4; i++) begin
            m_lane[i] = 32'h0000_0130 + 32'(i) * 32'h101;
            lane_init[i] = m_lane[i];
        end

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !done && !bus_rd && !bus_wr, "R1 in reset",
              {28'b0, busy, done, bus_rd, bus_wr}, 32'd0);
        rst_n = 1;
        @(negedge clk);
        check(!busy && !done && !bus_rd && !bus_wr && result == 2'd0, "R1 after reset",
              {26'b0, result, busy, done, bus_rd, bus_wr}, 32'd0);

        // single rank, ODT off, no misses, zero latency
        run(0, 0, 0, 0, 0, 0, 0, 2'd0, "R9");
        check(m_train[25:24] == 2'b01, "R6 single-rank field", {30'b0, m_train[25:24]}, 32'd1);
        for (int i = 0; i < 4; i++)
            check(m_lane[i] == ((lane_init[i] & ~32'h30) | 32'h20), "R8 lane ODT off",
                  m_lane[i], (lane_init[i] & ~32'h30) | 32'h20);
        check(m_pwr == 32'h0000_00F0, "R9 hold bits released", m_pwr, 32'h0000_00F0);

        // dual rank, dynamic ODT, polls with misses, bus stalls, request while busy
        run(1, 1, 2, 1, 3, 2, 1, 2'd0, "R10");
        check(m_train[25:24] == 2'b11, "R6 dual-rank field", {30'b0, m_train[25:24]}, 32'd3);
        for (int i = 0; i < 4; i++)
            check(m_lane[i][5:4] == 2'b00, "R8 lane dynamic ODT", m_lane[i], lane_init[i] & ~32'h30);
        check(m_pll[20] && m_pll[19:0] == 20'h01234, "R5 PLL other bits kept", m_pll, 32'h8010_1234);

        // boundary: POLL_MAX-1 misses in every phase still succeeds
        run(1, 0, PM - 1, PM - 1, PM - 1, 1, 0, 2'd0, "R11");

        // timeouts in each poll phase
        run(0, 0, 100, 0, 0, 0, 0, 2'd1, "R11");
        check(m_pwr[0] == 0 && m_pwr[8] == 0, "R11 entry abort clears hold",
              m_pwr, m_pwr & ~32'h101);
        run(0, 1, 0, 100, 0, 1, 0, 2'd2, "R11");
        check(m_pwr[0] == 0 && m_pwr[8] == 0, "R11 PHY abort clears hold",
              m_pwr, m_pwr & ~32'h101);
        run(1, 1, 0, 0, 100, 0, 0, 2'd3, "R11");

        // recovery: a clean run after the aborts
        run(0, 1, 1, 0, 0, 0, 0, 2'd0, "R9");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule